// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block drives a parallel NOR flash that uses the unlock-prefixed command set. One start pulse launches one operation: a single-word program, a sector erase, or a buffered program of up to sixteen words. The sequencer issues the bus writes of the chosen operation and then polls the device until the status toggle bit settles. A final read compares the stored value with the value that was written, and the block then reports the result on a one-cycle done pulse with an error code.

The port runs in 16-bit mode or in 8-bit mode. In 8-bit mode the magic command addresses change and only the low data byte is driven and compared. Every write strobe lasts one cycle and is followed by a cycle with the strobe high. For a buffered program the caller presents the words on `wr_data`. The block pulses `word_take` in the cycle it writes the current word, and the caller presents the next word in the cycle after.

The state machine has these states. IDLE waits for a start. UNLK1 and UNLK2 write the first unlock prefix. SETUP writes the operation command. UNLK3 and UNLK4 write the second prefix of an erase, and ERASE_GO writes the sector erase command. PROG_DATA writes the program word. BUF_CNT, BUF_WORD and BUF_CONFIRM write the buffered count, the words and the confirm. GAP is the idle cycle after every write, and it returns to the state stored with it. POLL1 and POLL2 are a pair of status reads. VERIFY is the final compare read. ABORT writes the reset command. DONE raises the done pulse.

The transitions are as follows. IDLE goes to UNLK1 on an accepted start. Each write state goes to GAP, and GAP goes on to the next write or to POLL1. From SETUP the path splits by operation, into UNLK3, PROG_DATA or BUF_CNT. BUF_WORD loops through GAP until the last word is written. POLL1 goes to POLL2. POLL2 goes back to POLL1 while the toggle bit is still moving. It goes to ABORT on a confirmed device error or on a timeout, and to VERIFY once the reads agree. VERIFY goes to DONE, ABORT goes through GAP to DONE, and DONE goes to IDLE.

Top module: `nor_cmd_seq`

## Requirements
- R1: In 16-bit mode (`byte_mode`=0) the unlock prefix is the write 0xAA at address 0x555 followed by the write 0x55 at address 0x2AA.
- R2: In 8-bit mode (`byte_mode`=1) the prefix addresses become 0xAAA and 0x555, the operation-start address becomes 0xAAA, and data bits 15:8 are driven as zero.
- R3: Program (`op`=0) writes, in order: the prefix, 0xA0 at the start address (0x555 in 16-bit mode), and `wr_data` at `tgt_addr`.
- R4: Erase (`op`=1) writes, in order: the prefix, 0x80 at the start address, the prefix again, and 0x30 at `sect_addr`.
- R5: Buffered program (`op`=2) writes, in order: the prefix, 0x25 at `sect_addr`, `wcount` (the word count minus one) at `sect_addr`, words 0..`wcount` at `tgt_addr`+i, and 0x29 at `sect_addr`. `word_take` pulses once per word.
- R6: `fl_we_n` is low for exactly one cycle per write and is high in the cycle after. `fl_we_n` and `fl_oe_n` are never low together.
- R7: After the last command write the block reads the poll address (the target for a program, the sector for an erase, the last word's address for a buffered program) in read pairs. Once bit 6 is equal in both reads of a pair, it makes one verify read and, if that read matches, ends with `err_code`=0.
- R8: A verify read whose value differs from the expected value (the written word, or all ones after an erase; low byte only in 8-bit mode) ends with `err_code`=3 and no reset write.
- R9: If bit 5 is set in a read pair that shows bit 6 toggling, and the next pair still toggles, the block writes 0xF0 at `sect_addr` and ends with `err_code`=2.
- R10: If bit 6 is still toggling after `tout` cycles of polling, the block writes 0xF0 at `sect_addr` and ends with `err_code`=1.
- R11: A start while busy, or a start with `op`=3, is ignored: no bus write occurs, `busy` stays as it was, and no done pulse follows.
- R12: After reset, `fl_we_n` and `fl_oe_n` are high and `busy` and `done` are low.
- R13: `busy` rises in the cycle after an accepted start. `done` is high for exactly one cycle, with `err_code` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation (one-cycle pulse) |
| op | input | 2 | 0 program, 1 erase, 2 buffered program, 3 reserved |
| byte_mode | input | 1 | 1 selects the 8-bit port addressing |
| sect_addr | input | AW | Sector address |
| tgt_addr | input | AW | Target address of a program or of the first buffered word |
| wr_data | input | DW | Program word, or the current buffered word |
| wcount | input | CNTW | Number of buffered words minus one |
| tout | input | TW | Polling timeout in cycles |
| word_take | output | 1 | The current buffered word is being written |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 device error, 3 verify mismatch |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash read strobe, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | DW | Flash write data |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_in | input | DW | Flash read data |

## Verification
On every cycle the assertions check the single-cycle write strobe and the idle cycle after it, the exclusion of read and write strobes, the one-cycle done pulse, and that busy rises only after a start. They also check that a confirmed bit-5 fault and an expired timeout each lead at once to the abort state with the right code. The exact order of addresses and data in each sequence, the address changes in 8-bit mode, and the per-word take handshake can only be shown by the bench's scenarios. The same holds for the verify mismatch, the ignored starts and the completion reached after a device model finishes its toggling.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG    = 2'd0,
        OP_ERASE   = 2'd1,
        OP_BUFPROG = 2'd2,
        OP_RSVD    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_DEVICE  = 2'd2,
        ERR_VERIFY  = 2'd3
    } err_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_SETUP,
        ST_UNLK3,
        ST_UNLK4,
        ST_ERASE_GO,
        ST_PROG_DATA,
        ST_BUF_CNT,
        ST_BUF_WORD,
        ST_BUF_CONFIRM,
        ST_GAP,
        ST_POLL1,
        ST_POLL2,
        ST_VERIFY,
        ST_ABORT,
        ST_DONE
    } seq_state_e;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERSET  = 8'h80;
    localparam logic [7:0] CODE_ERGO   = 8'h30;
    localparam logic [7:0] CODE_BUFLD  = 8'h25;
    localparam logic [7:0] CODE_BUFGO  = 8'h29;
    localparam logic [7:0] CODE_RESET  = 8'hF0;

    localparam logic [11:0] ADR_W16_A = 12'h555;
    localparam logic [11:0] ADR_W16_B = 12'h2AA;
    localparam logic [11:0] ADR_W8_A  = 12'hAAA;
    localparam logic [11:0] ADR_W8_B  = 12'h555;

endpackage

// File: rtl/nor_tmo_ctr.sv
module nor_tmo_ctr #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != {TW{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/nor_toggle_poll.sv
module nor_toggle_poll (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic tog_bit,
    input  logic err_bit,
    output logic toggled,
    output logic fault
);
    logic first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (capture) begin
            first_q <= tog_bit;
        end
    end

    assign toggled = first_q ^ tog_bit;
    assign fault   = toggled & err_bit;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int CNTW    = 4,
    parameter int TW      = 20,
    parameter int TOG_POS = 6,
    parameter int ERR_POS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic            byte_mode,
    input  logic [AW-1:0]   sect_addr,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [CNTW-1:0] wcount,
    input  logic [TW-1:0]   tout,
    output logic            word_take,
    output logic            busy,
    output logic            done,
    output logic [1:0]      err_code,
    output logic            fl_we_n,
    output logic            fl_oe_n,
    output logic [AW-1:0]   fl_addr,
    output logic [DW-1:0]   fl_dq_out,
    output logic            fl_dq_oe,
    input  logic [DW-1:0]   fl_dq_in
);
    localparam logic [DW-1:0] MASK_W8  = DW'(8'hFF);
    localparam logic [DW-1:0] MASK_ALL = {DW{1'b1}};

    seq_state_e state_q, nxt_state, ret_q, nxt_ret;
    op_e        op_in, op_q;
    err_e       err_q;
    logic            byte_q;
    logic [AW-1:0]   sect_q, tgt_q, poll_addr, adr_a, adr_b;
    logic [DW-1:0]   exp_q, dmask;
    logic [CNTW-1:0] wcnt_q, idx_q;
    logic [TW-1:0]   tout_q;
    logic            fault_seen_q;
    logic            accept, in_poll, tgl, flt, tmo_exp, mismatch;

    assign op_in  = op_e'(op);
    assign accept = (state_q == ST_IDLE) && start && (op_in != OP_RSVD);
    assign in_poll = (state_q == ST_POLL1) || (state_q == ST_POLL2);
    assign dmask  = byte_q ? MASK_W8 : MASK_ALL;
    assign adr_a  = byte_q ? AW'(ADR_W8_A) : AW'(ADR_W16_A);
    assign adr_b  = byte_q ? AW'(ADR_W8_B) : AW'(ADR_W16_B);
    assign mismatch = ((fl_dq_in ^ exp_q) & dmask) != '0;

    always_comb begin
        unique case (op_q)
            OP_ERASE:   poll_addr = sect_q;
            OP_BUFPROG: poll_addr = tgt_q + AW'(wcnt_q);
            default:    poll_addr = tgt_q;
        endcase
    end

    nor_toggle_poll u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state_q == ST_POLL1),
        .tog_bit (fl_dq_in[TOG_POS]),
        .err_bit (fl_dq_in[ERR_POS]),
        .toggled (tgl),
        .fault   (flt)
    );

    nor_tmo_ctr #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!in_poll),
        .en      (in_poll),
        .limit   (tout_q),
        .expired (tmo_exp)
    );

    // next-state selection
    always_comb begin
        nxt_state = state_q;
        nxt_ret   = ret_q;
        unique case (state_q)
            ST_IDLE:        if (accept) nxt_state = ST_UNLK1;
            ST_UNLK1:       begin nxt_state = ST_GAP; nxt_ret = ST_UNLK2; end
            ST_UNLK2:       begin nxt_state = ST_GAP; nxt_ret = ST_SETUP; end
            ST_SETUP: begin
                nxt_state = ST_GAP;
                unique case (op_q)
                    OP_ERASE:   nxt_ret = ST_UNLK3;
                    OP_BUFPROG: nxt_ret = ST_BUF_CNT;
                    default:    nxt_ret = ST_PROG_DATA;
                endcase
            end
            ST_UNLK3:       begin nxt_state = ST_GAP; nxt_ret = ST_UNLK4; end
            ST_UNLK4:       begin nxt_state = ST_GAP; nxt_ret = ST_ERASE_GO; end
            ST_ERASE_GO:    begin nxt_state = ST_GAP; nxt_ret = ST_POLL1; end
            ST_PROG_DATA:   begin nxt_state = ST_GAP; nxt_ret = ST_POLL1; end
            ST_BUF_CNT:     begin nxt_state = ST_GAP; nxt_ret = ST_BUF_WORD; end
            ST_BUF_WORD: begin
                nxt_state = ST_GAP;
                nxt_ret   = (idx_q == wcnt_q) ? ST_BUF_CONFIRM : ST_BUF_WORD;
            end
            ST_BUF_CONFIRM: begin nxt_state = ST_GAP; nxt_ret = ST_POLL1; end
            ST_GAP:         nxt_state = ret_q;
            ST_POLL1:       nxt_state = ST_POLL2;
            ST_POLL2: begin
                if (!tgl)                    nxt_state = ST_VERIFY;
                else if (fault_seen_q)       nxt_state = ST_ABORT;
                else if (flt)                nxt_state = ST_POLL1;
                else if (tmo_exp)            nxt_state = ST_ABORT;
                else                         nxt_state = ST_POLL1;
            end
            ST_VERIFY:      nxt_state = ST_DONE;
            ST_ABORT:       begin nxt_state = ST_GAP; nxt_ret = ST_DONE; end
            ST_DONE:        nxt_state = ST_IDLE;
            default:        nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ret_q   <= ST_IDLE;
        end else begin
            state_q <= nxt_state;
            ret_q   <= nxt_ret;
        end
    end

    // operation context and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q         <= OP_PROG;
            err_q        <= ERR_NONE;
            byte_q       <= 1'b0;
            sect_q       <= '0;
            tgt_q        <= '0;
            exp_q        <= '0;
            wcnt_q       <= '0;
            idx_q        <= '0;
            tout_q       <= '0;
            fault_seen_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q         <= op_in;
                    err_q        <= ERR_NONE;
                    byte_q       <= byte_mode;
                    sect_q       <= sect_addr;
                    tgt_q        <= tgt_addr;
                    wcnt_q       <= wcount;
                    tout_q       <= tout;
                    idx_q        <= '0;
                    fault_seen_q <= 1'b0;
                    exp_q        <= (op_in == OP_ERASE) ? MASK_ALL : wr_data;
                end
                ST_BUF_WORD: begin
                    exp_q <= wr_data;
                    idx_q <= idx_q + 1'b1;
                end
                ST_POLL2: if (tgl) begin
                    if (fault_seen_q)  err_q <= ERR_DEVICE;
                    else if (flt)      fault_seen_q <= 1'b1;
                    else if (tmo_exp)  err_q <= ERR_TIMEOUT;
                end
                ST_VERIFY: if (mismatch) err_q <= ERR_VERIFY;
                default: ;
            endcase
        end
    end

    // bus and status outputs
    always_comb begin
        fl_we_n   = 1'b1;
        fl_oe_n   = 1'b1;
        fl_addr   = '0;
        fl_dq_out = '0;
        word_take = 1'b0;
        unique case (state_q)
            ST_UNLK1, ST_UNLK3: begin
                fl_we_n = 1'b0; fl_addr = adr_a; fl_dq_out = DW'(KEY_FIRST);
            end
            ST_UNLK2, ST_UNLK4: begin
                fl_we_n = 1'b0; fl_addr = adr_b; fl_dq_out = DW'(KEY_SECOND);
            end
            ST_SETUP: begin
                fl_we_n = 1'b0;
                unique case (op_q)
                    OP_ERASE:   begin fl_addr = adr_a;  fl_dq_out = DW'(CODE_ERSET); end
                    OP_BUFPROG: begin fl_addr = sect_q; fl_dq_out = DW'(CODE_BUFLD); end
                    default:    begin fl_addr = adr_a;  fl_dq_out = DW'(CODE_PROG);  end
                endcase
            end
            ST_ERASE_GO: begin
                fl_we_n = 1'b0; fl_addr = sect_q; fl_dq_out = DW'(CODE_ERGO);
            end
            ST_PROG_DATA: begin
                fl_we_n = 1'b0; fl_addr = tgt_q; fl_dq_out = exp_q & dmask;
            end
            ST_BUF_CNT: begin
                fl_we_n = 1'b0; fl_addr = sect_q; fl_dq_out = DW'(wcnt_q);
            end
            ST_BUF_WORD: begin
                fl_we_n   = 1'b0;
                fl_addr   = tgt_q + AW'(idx_q);
                fl_dq_out = wr_data & dmask;
                word_take = 1'b1;
            end
            ST_BUF_CONFIRM: begin
                fl_we_n = 1'b0; fl_addr = sect_q; fl_dq_out = DW'(CODE_BUFGO);
            end
            ST_ABORT: begin
                fl_we_n = 1'b0; fl_addr = sect_q; fl_dq_out = DW'(CODE_RESET);
            end
            ST_POLL1, ST_POLL2, ST_VERIFY: begin
                fl_oe_n = 1'b0; fl_addr = poll_addr;
            end
            default: ;
        endcase
    end

    assign fl_dq_oe = !fl_we_n;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign err_code = err_q;

    // ---------------- assertions ----------------
    assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we_n || fl_oe_n);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_device_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL2 && tgl && fault_seen_q)
        |=> (state_q == ST_ABORT && err_q == ERR_DEVICE));

    assert_timeout_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL2 && tgl && !fault_seen_q && !flt && tmo_exp)
        |=> (state_q == ST_ABORT && err_q == ERR_TIMEOUT));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        byte_mode = 1'b0;
    logic [23:0] sect_addr = '0;
    logic [23:0] tgt_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  wcount = '0;
    logic [19:0] tout = '0;
    logic        word_take, busy, done, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [1:0]  err_code;
    logic [23:0] fl_addr;
    logic [15:0] fl_dq_out, fl_dq_in;

    always #10 clk = ~clk;

    nor_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .byte_mode(byte_mode),
        .sect_addr(sect_addr), .tgt_addr(tgt_addr), .wr_data(wr_data),
        .wcount(wcount), .tout(tout), .word_take(word_take), .busy(busy),
        .done(done), .err_code(err_code), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // flash device model: logs writes, toggles bit 6 while busy
    logic [23:0] lg_a [2048];
    logic [15:0] lg_d [2048];
    int  lg_n = 0;
    int  reads_left = 0;
    int  viol = 0;
    bit  m_busy = 0, m_tog = 0, prev_we_low = 0;
    int  lg_base = 0, exp_len = 0, busy_len = 1;
    bit  m_hang = 0, m_e5 = 0;
    logic [15:0] m_val = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!fl_we_n) begin
            if (lg_n < 2048) begin
                lg_a[lg_n] <= fl_addr;
                lg_d[lg_n] <= fl_dq_out;
            end
            lg_n <= lg_n + 1;
            if (lg_n + 1 == lg_base + exp_len) begin
                m_busy     <= 1'b1;
                reads_left <= busy_len;
            end
            if (m_busy && fl_dq_out[7:0] == 8'hF0) m_busy <= 1'b0;
        end
        if ((!fl_we_n && prev_we_low) || (!fl_we_n && !fl_oe_n)) viol <= viol + 1;
        prev_we_low <= !fl_we_n;
        if (!fl_oe_n && m_busy) begin
            m_tog <= ~m_tog;
            if (!m_hang) begin
                if (reads_left <= 1) m_busy <= 1'b0;
                reads_left <= reads_left - 1;
            end
        end
    end

    assign fl_dq_in = fl_oe_n ? 16'h0 :
                      (m_busy ? {9'b0, m_tog, m_e5, 5'b0} : m_val);

    // watchdog
    initial begin
        wait (cycles > 150000);
        errors = errors + 1;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // expected write sequence
    logic [23:0] ex_a [64];
    logic [15:0] ex_d [64];
    int ex_n;
    logic [15:0] bw [16];

    task automatic push(input logic [23:0] a, input logic [15:0] d);
        ex_a[ex_n] = a;
        ex_d[ex_n] = d;
        ex_n = ex_n + 1;
    endtask

    function automatic logic [15:0] bmask(input bit bm);
        return bm ? 16'h00FF : 16'hFFFF;
    endfunction

    task automatic run_op(input int opv, input bit bm, input logic [23:0] sa,
                          input logic [23:0] ta, input logic [15:0] dat, input int wc,
                          input int tov, input int blen, input bit hang, input bit e5,
                          input bit corrupt, input bit poke, input int exp_err,
                          input string req);
        logic [23:0] a1, a2;
        logic [15:0] expv, m;
        int base_len, cyc, k, takes, n;
        bit take_prev, seq_ok;
        m  = bmask(bm);
        a1 = bm ? 24'hAAA : 24'h555;
        a2 = bm ? 24'h555 : 24'h2AA;
        ex_n = 0;
        push(a1, 16'hAA);
        push(a2, 16'h55);
        if (opv == 0) begin
            push(a1, 16'hA0); push(ta, dat & m); expv = dat;
        end else if (opv == 1) begin
            push(a1, 16'h80); push(a1, 16'hAA); push(a2, 16'h55); push(sa, 16'h30);
            expv = 16'hFFFF;
        end else begin
            push(sa, 16'h25); push(sa, 16'(wc));
            for (int i = 0; i <= wc; i++) push(ta + 24'(i), bw[i] & m);
            push(sa, 16'h29);
            expv = bw[wc];
        end
        base_len = ex_n;
        if (exp_err == 1 || exp_err == 2) push(sa, 16'hF0);

        lg_base  = lg_n;
        exp_len  = base_len;
        busy_len = blen;
        m_hang   = hang;
        m_e5     = e5;
        m_val    = corrupt ? (expv ^ 16'h0001) : expv;

        @(negedge clk);
        start = 1'b1; op = 2'(opv); byte_mode = bm; sect_addr = sa; tgt_addr = ta;
        wr_data = (opv == 2) ? bw[0] : dat; wcount = 4'(wc); tout = 20'(tov);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R13 busy after start", busy, 1);
        cyc = 0; k = 0; takes = 0; take_prev = 0;
        while (!done && cyc < 4000) begin
            if (take_prev) begin
                k = k + 1;
                if (k < 16) wr_data = bw[k];
            end
            take_prev = word_take;
            if (word_take) takes = takes + 1;
            if (poke && cyc == 3) begin start = 1'b1; op = 2'd1; end
            else start = 1'b0;
            @(negedge clk);
            cyc = cyc + 1;
        end
        chk(done == 1'b1, {req, " done reached"}, done, 1);
        chk(err_code == 2'(exp_err), {req, " err_code"}, err_code, exp_err);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R13 done one cycle", {done, busy}, 0);
        n = lg_n - lg_base;
        seq_ok = (n == ex_n);
        for (int i = 0; i < ex_n && seq_ok; i++)
            if (lg_a[lg_base + i] !== ex_a[i] || lg_d[lg_base + i] !== ex_d[i]) begin
                seq_ok = 0;
                $display("FAIL %s write %0d: actual %0h:%0h expected %0h:%0h", req, i,
                         lg_a[lg_base + i], lg_d[lg_base + i], ex_a[i], ex_d[i]);
            end
        chk(seq_ok, {req, " write sequence (count)"}, n, ex_n);
        if (opv == 2) chk(takes == wc + 1, "R5 word_take pulses", takes, wc + 1);
        chk(viol == 0, "R6 strobe spacing", viol, 0);
    endtask

    initial begin
        int seedv, lg0, bad;
        seedv = $urandom(32'd1234);
        for (int i = 0; i < 16; i++) bw[i] = 16'(16'h1000 + i * 16'h0111);

        repeat (3) @(negedge clk);
        chk(fl_we_n && fl_oe_n && !busy && !done, "R12 reset state",
            {fl_we_n, fl_oe_n, busy, done}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);

        // directed sequences
        run_op(0, 0, 24'h4000, 24'h4012, 16'hBEEF, 0, 1000, 3, 0, 0, 0, 0, 0, "R1 R3 R7");
        run_op(0, 1, 24'h2000, 24'h2034, 16'h5A3C, 0, 1000, 2, 0, 0, 0, 0, 0, "R2 R3");
        run_op(1, 0, 24'h8000, 24'h0, 16'h0, 0, 1000, 5, 0, 0, 0, 0, 0, "R4 R7");
        run_op(1, 1, 24'h6000, 24'h0, 16'h0, 0, 1000, 4, 0, 0, 0, 0, 0, "R2 R4");
        run_op(2, 0, 24'h1000, 24'h1100, 16'h0, 15, 1000, 6, 0, 0, 0, 0, 0, "R5 max");
        run_op(2, 1, 24'h3000, 24'h3010, 16'h0, 0, 1000, 1, 0, 0, 0, 0, 0, "R5 single");
        run_op(0, 0, 24'h4000, 24'h4040, 16'h1234, 0, 1000, 3, 0, 0, 1, 0, 3, "R8");
        run_op(1, 0, 24'h5000, 24'h0, 16'h0, 0, 1000, 3, 0, 1, 0, 0, 2, "R9");
        run_op(0, 0, 24'h7000, 24'h7001, 16'h0F0F, 0, 25, 1, 1, 0, 0, 0, 1, "R10");
        run_op(0, 0, 24'h7000, 24'h7002, 16'hCAFE, 0, 1000, 4, 0, 0, 0, 1, 0, "R11 poke");

        // reserved operation code is ignored
        lg0 = lg_n; bad = 0;
        @(negedge clk);
        start = 1'b1; op = 2'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (busy || done) bad = bad + 1;
            @(negedge clk);
        end
        chk(bad == 0 && lg_n == lg0, "R11 reserved op", bad + lg_n - lg0, 0);

        // random operations
        for (int t = 0; t < 12; t++) begin
            int opr, wc;
            bit bm;
            logic [15:0] d;
            opr = int'($urandom_range(2, 0));
            bm  = 1'($urandom_range(1, 0));
            wc  = int'($urandom_range(15, 0));
            d   = 16'($urandom);
            for (int i = 0; i < 16; i++) bw[i] = 16'($urandom);
            run_op(opr, bm, 24'($urandom) & 24'hFFF000, 24'($urandom) & 24'hFFFFF0,
                   d, wc, 1000, int'($urandom_range(8, 1)), 0, 0, 0, 0, 0, "R7 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule